// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries for an Ethernet switch. Each entry holds a 12-bit VLAN identifier, a member port mask and a valid flag. Software changes the table through two 32-bit registers. A data register holds the mask and the valid flag for the next load. A command register holds the operation, its operands, a self-clearing active bit and a table-full status bit.

Software writes the command register with the active bit set. The engine then stays busy for a fixed number of cycles, equal to the table depth. When that time is up, it applies the operation and drops the active bit. The operation is one of: nothing, clear the whole table, load an entry, drop one VLAN, or strip one port from every entry. Software polls the active bit before it issues the next command.

The forwarding logic reads the table through a lookup port. It presents a VLAN identifier and, in the same cycle, gets the member mask and a hit flag.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the command readback and the data readback are zero, the table holds no valid entry, and every lookup misses with a zero mask.
- R2: Command word layout: operation code in bits 2:0 (0 nothing, 1 clear all, 2 load, 3 drop VLAN, 4 strip port; 5 to 7 act as nothing), active in bit 3, full status in bit 4, port number in bits 11:8, VLAN identifier in bits 27:16, priority in bits 30:28, priority enable in bit 31. The readback returns the stored fields with all other bits zero. A write ignores bit 4, and a write with bit 3 clear stores the fields but starts nothing.
- R3: After an accepted write with bit 3 set, the active bit reads 1 for exactly DEPTH cycles. The table change becomes visible in the cycle in which the active bit reads 0.
- R4: Writes to the command register or the data register are ignored while the active bit is set, including in the last busy cycle.
- R5: A load of a VLAN identifier that is not in the table stores it in a free slot, with the mask from data bits 9:0 and the valid flag from data bit 11.
- R6: A load of a VLAN identifier that is already valid in the table overwrites that entry and uses no other slot.
- R7: A load of a new identifier while all DEPTH slots are valid leaves the table unchanged and sets the full bit (command bit 4). Any later completed command that does not hit this case clears the full bit.
- R8: Drop VLAN invalidates the entry whose identifier matches and leaves the other entries as they were. An absent identifier changes nothing.
- R9: Strip port clears the given port's bit in the mask of every valid entry. A port number of 10 or more changes nothing.
- R10: Clear all invalidates every entry.
- R11: The lookup port returns the hit flag and the member mask of a presented identifier in the same cycle, and returns a zero mask on a miss.
- R12: The data register reads back the mask in bits 9:0 and the valid flag in bit 11, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command register write value |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 32 | Data register write value |
| cmd_rdata | output | 32 | Command register readback, including active and full |
| data_rdata | output | 32 | Data register readback |
| lk_vid | input | 12 | VLAN identifier to look up |
| lk_mask | output | 10 | Member mask of the looked-up identifier |
| lk_hit | output | 1 | The looked-up identifier is valid in the table |

## Verification
Two things can meet on one clock edge: a software register write and the completion of the running command, where the table changes and the active bit drops. The bench provokes this with a command write and a data write that are both sampled on the exact edge where a no-op finishes. It then checks that the operation field, the data readback and the lookup of the identifier in the rejected load are all unchanged. The lookup port is also read right after each completion, to show that the new table contents appear in the same cycle in which the active bit reads 0.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;
   typedef enum logic [2:0] {
      VOP_NOP    = 3'd0,
      VOP_FLUSH  = 3'd1,
      VOP_LOAD   = 3'd2,
      VOP_PURGE  = 3'd3,
      VOP_RMPORT = 3'd4
   } vlan_op_e;

   localparam int CMD_OP_LSB    = 0;
   localparam int CMD_ACT_BIT   = 3;
   localparam int CMD_FULL_BIT  = 4;
   localparam int CMD_PORT_LSB  = 8;
   localparam int CMD_VID_LSB   = 16;
   localparam int CMD_PRIO_LSB  = 28;
   localparam int CMD_PRIEN_BIT = 31;
   localparam int DAT_VALID_BIT = 11;
endpackage

// File: rtl/vlan_low_pick.sv
module vlan_low_pick #(
   parameter int N     = 16,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IW'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vlan_entry_store.sv
module vlan_entry_store
   import vlan_cmd_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int PORTS  = 10,
   parameter int PIDX_W = 4,
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        exec,
   input  vlan_op_e                    op,
   input  logic [VID_W-1:0]            cmd_vid,
   input  logic [PIDX_W-1:0]           cmd_port,
   input  logic [PORTS-1:0]            wr_mask,
   input  logic                        wr_valid,
   output logic [DEPTH-1:0]            ent_valid,
   output logic [DEPTH-1:0][VID_W-1:0] ent_vid,
   output logic [DEPTH-1:0][PORTS-1:0] ent_mask,
   output logic                        load_blocked
);
   logic [DEPTH-1:0] match;
   logic [IW-1:0]    match_idx, free_idx, tgt_idx;
   logic             any_match, any_free, do_load;
   logic [PORTS-1:0] port_bit;

   always_comb begin
      for (int i = 0; i < DEPTH; i++)
         match[i] = ent_valid[i] && (ent_vid[i] == cmd_vid);
   end

   vlan_low_pick #(.N(DEPTH)) u_match_pick (
      .req (match), .idx (match_idx), .any (any_match));

   vlan_low_pick #(.N(DEPTH)) u_free_pick (
      .req (~ent_valid), .idx (free_idx), .any (any_free));

   assign tgt_idx      = any_match ? match_idx : free_idx;
   assign load_blocked = !any_match && !any_free;
   assign do_load      = exec && (op == VOP_LOAD) && !load_blocked;

   always_comb begin
      port_bit = '0;
      for (int p = 0; p < PORTS; p++)
         if (32'(cmd_port) == p) port_bit[p] = 1'b1;
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[s] <= 1'b0;
            ent_vid[s]   <= '0;
            ent_mask[s]  <= '0;
         end else if (exec) begin
            case (op)
               VOP_FLUSH: ent_valid[s] <= 1'b0;
               VOP_LOAD: begin
                  if (do_load && (tgt_idx == IW'(s))) begin
                     ent_vid[s]   <= cmd_vid;
                     ent_mask[s]  <= wr_mask;
                     ent_valid[s] <= wr_valid;
                  end
               end
               VOP_PURGE: begin
                  if (match[s]) ent_valid[s] <= 1'b0;
               end
               VOP_RMPORT: begin
                  if (ent_valid[s]) ent_mask[s] <= ent_mask[s] & ~port_bit;
               end
               default: ;
            endcase
         end
      end
   end

   assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == VOP_FLUSH) |=> (ent_valid == '0));

   assert_purge_gone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == VOP_PURGE) |=> !any_match);

   assert_load_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (do_load && wr_valid) |=> any_match);
endmodule

// File: rtl/vlan_lookup.sv
module vlan_lookup #(
   parameter int DEPTH = 16,
   parameter int VID_W = 12,
   parameter int PORTS = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DEPTH-1:0]            ent_valid,
   input  logic [DEPTH-1:0][VID_W-1:0] ent_vid,
   input  logic [DEPTH-1:0][PORTS-1:0] ent_mask,
   input  logic [VID_W-1:0]            q_vid,
   output logic [PORTS-1:0]            q_mask,
   output logic                        q_hit
);
   logic [DEPTH-1:0] q_match;

   always_comb begin
      q_mask = '0;
      for (int i = 0; i < DEPTH; i++) begin
         q_match[i] = ent_valid[i] && (ent_vid[i] == q_vid);
         if (q_match[i]) q_mask = q_mask | ent_mask[i];
      end
   end
   assign q_hit = |q_match;

   assert_unique_vid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_match));
endmodule

// File: rtl/vlan_cmd_seq.sv
module vlan_cmd_seq
   import vlan_cmd_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int PORTS  = 10,
   parameter int PIDX_W = 4,
   parameter int PRIO_W = 3,
   localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [31:0]       cmd_wdata,
   input  logic              data_we,
   input  logic [31:0]       data_wdata,
   input  logic              load_blocked,
   output vlan_op_e          op,
   output logic [VID_W-1:0]  cmd_vid,
   output logic [PIDX_W-1:0] cmd_port,
   output logic [PORTS-1:0]  wr_mask,
   output logic              wr_valid,
   output logic              exec,
   output logic              busy,
   output logic              full,
   output logic [31:0]       cmd_rdata,
   output logic [31:0]       data_rdata
);
   logic [2:0]        op_q;
   logic [PRIO_W-1:0] prio_q;
   logic              prien_q;
   logic [CNT_W-1:0]  cnt;
   logic              accept, dacc;

   assign accept = cmd_we && !busy;
   assign dacc   = data_we && !busy;
   assign exec   = busy && (cnt == '0);
   assign op     = vlan_op_e'(op_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= '0; cmd_port <= '0; cmd_vid <= '0;
         prio_q <= '0; prien_q <= 1'b0;
         busy <= 1'b0; cnt <= '0; full <= 1'b0;
      end else if (accept) begin
         op_q     <= cmd_wdata[CMD_OP_LSB +: 3];
         cmd_port <= cmd_wdata[CMD_PORT_LSB +: PIDX_W];
         cmd_vid  <= cmd_wdata[CMD_VID_LSB +: VID_W];
         prio_q   <= cmd_wdata[CMD_PRIO_LSB +: PRIO_W];
         prien_q  <= cmd_wdata[CMD_PRIEN_BIT];
         busy     <= cmd_wdata[CMD_ACT_BIT];
         cnt      <= CNT_W'(DEPTH - 1);
      end else if (busy) begin
         if (exec) begin
            busy <= 1'b0;
            full <= (op == VOP_LOAD) && load_blocked;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_mask  <= '0;
         wr_valid <= 1'b0;
      end else if (dacc) begin
         wr_mask  <= data_wdata[PORTS-1:0];
         wr_valid <= data_wdata[DAT_VALID_BIT];
      end
   end

   always_comb begin
      cmd_rdata = '0;
      cmd_rdata[CMD_OP_LSB +: 3]        = op_q;
      cmd_rdata[CMD_ACT_BIT]            = busy;
      cmd_rdata[CMD_FULL_BIT]           = full;
      cmd_rdata[CMD_PORT_LSB +: PIDX_W] = cmd_port;
      cmd_rdata[CMD_VID_LSB +: VID_W]   = cmd_vid;
      cmd_rdata[CMD_PRIO_LSB +: PRIO_W] = prio_q;
      cmd_rdata[CMD_PRIEN_BIT]          = prien_q;
      data_rdata = '0;
      data_rdata[PORTS-1:0]    = wr_mask;
      data_rdata[DAT_VALID_BIT] = wr_valid;
   end

   assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy);

   assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exec |=> !busy);

   assert_cmd_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we) |=> ($stable(op_q) && $stable(cmd_vid)));

   assert_data_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && data_we) |=> ($stable(wr_mask) && $stable(wr_valid)));
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
   import vlan_cmd_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int PORTS  = 10,
   parameter int PIDX_W = 4,
   parameter int PRIO_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [31:0]      cmd_wdata,
   input  logic             data_we,
   input  logic [31:0]      data_wdata,
   output logic [31:0]      cmd_rdata,
   output logic [31:0]      data_rdata,
   input  logic [VID_W-1:0] lk_vid,
   output logic [PORTS-1:0] lk_mask,
   output logic             lk_hit
);
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("vlan_cmd_engine: DEPTH out of range");
   end
   if (VID_W > 12 || VID_W < 1) begin : g_bad_vid
      $error("vlan_cmd_engine: VID_W must fit bits 27:16");
   end
   if (PORTS > 10 || PORTS < 1) begin : g_bad_ports
      $error("vlan_cmd_engine: PORTS must fit data bits 9:0");
   end
   if (PIDX_W > 4 || PRIO_W > 3) begin : g_bad_fields
      $error("vlan_cmd_engine: port or priority field too wide");
   end

   vlan_op_e                    op;
   logic [VID_W-1:0]            cmd_vid;
   logic [PIDX_W-1:0]           cmd_port;
   logic [PORTS-1:0]            wr_mask;
   logic                        wr_valid, exec, busy, full, load_blocked;
   logic [DEPTH-1:0]            ent_valid;
   logic [DEPTH-1:0][VID_W-1:0] ent_vid;
   logic [DEPTH-1:0][PORTS-1:0] ent_mask;

   vlan_cmd_seq #(.DEPTH(DEPTH), .VID_W(VID_W), .PORTS(PORTS),
                  .PIDX_W(PIDX_W), .PRIO_W(PRIO_W)) u_seq (
      .clk, .rst_n, .cmd_we, .cmd_wdata, .data_we, .data_wdata,
      .load_blocked, .op, .cmd_vid, .cmd_port, .wr_mask, .wr_valid,
      .exec, .busy, .full, .cmd_rdata, .data_rdata);

   vlan_entry_store #(.DEPTH(DEPTH), .VID_W(VID_W), .PORTS(PORTS),
                      .PIDX_W(PIDX_W)) u_store (
      .clk, .rst_n, .exec, .op, .cmd_vid, .cmd_port, .wr_mask, .wr_valid,
      .ent_valid, .ent_vid, .ent_mask, .load_blocked);

   vlan_lookup #(.DEPTH(DEPTH), .VID_W(VID_W), .PORTS(PORTS)) u_lookup (
      .clk, .rst_n, .ent_valid, .ent_vid, .ent_mask,
      .q_vid (lk_vid), .q_mask (lk_mask), .q_hit (lk_hit));

   assert_full_means_packed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> ($countones(ent_valid) == DEPTH));

   assert_full_keeps_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == VOP_LOAD && load_blocked) |=> $stable(ent_valid));
endmodule

// File: tb/vlan_cmd_engine_test.sv
module vlan_cmd_engine_test;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0, data_we = 1'b0;
   logic [31:0] cmd_wdata = '0, data_wdata = '0;
   logic [31:0] cmd_rdata, data_rdata;
   logic [11:0] lk_vid = '0;
   logic [9:0]  lk_mask;
   logic        lk_hit;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   vlan_cmd_engine uut (
      .clk, .rst_n, .cmd_we, .cmd_wdata, .data_we, .data_wdata,
      .cmd_rdata, .data_rdata, .lk_vid, .lk_mask, .lk_hit);

   function automatic logic [31:0] mk_cmd(input logic [2:0] op, input logic [3:0] port,
                                          input logic [11:0] vid, input logic act);
      return {1'b0, 3'd0, vid, 4'd0, port, 3'd0, 1'b0, act, op};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_data(input logic [31:0] v);
      @(negedge clk); data_we = 1'b1; data_wdata = v;
      @(posedge clk); @(negedge clk); data_we = 1'b0;
   endtask

   task automatic issue(input logic [31:0] v);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
      @(posedge clk); @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic run(input logic [31:0] v, output int busy_cycles);
      issue(v);
      busy_cycles = 0;
      while (cmd_rdata[3] && busy_cycles < 100) begin
         busy_cycles++;
         @(negedge clk);
      end
   endtask

   task automatic lk(input logic [11:0] vid, input bit hit, input logic [9:0] mask,
                     input string req);
      lk_vid = vid; #1;
      check(lk_hit == hit, req, 32'(lk_hit), 32'(hit));
      check(lk_mask == mask, req, 32'(lk_mask), 32'(mask));
   endtask

   task automatic t_reset;
      check(cmd_rdata == 0, "R1", cmd_rdata, 0);
      check(data_rdata == 0, "R1", data_rdata, 0);
      lk(12'd1, 0, '0, "R1");
      lk(12'd0, 0, '0, "R1");
   endtask

   task automatic t_fields;
      logic [31:0] w;
      w = {1'b1, 3'd5, 12'hABC, 4'hF, 4'h7, 3'b111, 1'b1, 1'b0, 3'd3};
      issue(w);
      check(cmd_rdata == 32'hDABC_0703, "R2", cmd_rdata, 32'hDABC_0703);
      wr_data(32'hFFFF_FFFF);
      check(data_rdata == 32'h0000_0BFF, "R12", data_rdata, 32'h0000_0BFF);
      lk(12'hABC, 0, '0, "R2");
   endtask

   task automatic t_timing;
      int n;
      run(mk_cmd(3'd0, 4'd0, 12'd5, 1'b1), n);
      check(n == DEPTH, "R3", n, DEPTH);
      run(mk_cmd(3'd6, 4'd0, 12'd5, 1'b1), n);
      check(n == DEPTH, "R3", n, DEPTH);
      check(cmd_rdata[4] == 1'b0, "R2", cmd_rdata, 0);
   endtask

   task automatic t_load;
      int n;
      wr_data(32'h0000_0805);
      issue(mk_cmd(3'd2, 4'd0, 12'd100, 1'b1));
      repeat (DEPTH - 1) @(negedge clk);
      lk(12'd100, 0, '0, "R3");
      @(negedge clk);
      check(cmd_rdata[3] == 1'b0, "R3", cmd_rdata, 0);
      lk(12'd100, 1, 10'h005, "R5");
      lk(12'd101, 0, '0, "R11");
      n = 0;
   endtask

   task automatic t_fill;
      int n;
      for (int i = 0; i < DEPTH - 1; i++) begin
         wr_data(32'h800 | 32'(i + 1));
         run(mk_cmd(3'd2, 4'd0, 12'(200 + i), 1'b1), n);
      end
      lk(12'd214, 1, 10'd15, "R5");
      check(cmd_rdata[4] == 1'b0, "R7", cmd_rdata, 0);
      wr_data(32'h0000_0BF0);
      run(mk_cmd(3'd2, 4'd0, 12'd100, 1'b1), n);
      check(cmd_rdata[4] == 1'b0, "R6", cmd_rdata, 0);
      lk(12'd100, 1, 10'h3F0, "R6");
      wr_data(32'h0000_0BFF);
      run(mk_cmd(3'd2, 4'd0, 12'd999, 1'b1), n);
      check(cmd_rdata[4] == 1'b1, "R7", cmd_rdata, 32'h10);
      lk(12'd999, 0, '0, "R7");
      lk(12'd200, 1, 10'd1, "R7");
      run(mk_cmd(3'd0, 4'd0, 12'd0, 1'b1), n);
      check(cmd_rdata[4] == 1'b0, "R7", cmd_rdata, 0);
   endtask

   task automatic t_purge;
      int n;
      run(mk_cmd(3'd3, 4'd0, 12'd555, 1'b1), n);
      lk(12'd100, 1, 10'h3F0, "R8");
      lk(12'd201, 1, 10'd2, "R8");
      run(mk_cmd(3'd3, 4'd0, 12'd200, 1'b1), n);
      lk(12'd200, 0, '0, "R8");
      lk(12'd201, 1, 10'd2, "R8");
      run(mk_cmd(3'd2, 4'd0, 12'd999, 1'b1), n);
      check(cmd_rdata[4] == 1'b0, "R7", cmd_rdata, 0);
      lk(12'd999, 1, 10'h3FF, "R5");
   endtask

   task automatic t_rmport;
      int n;
      run(mk_cmd(3'd4, 4'd4, 12'd0, 1'b1), n);
      lk(12'd100, 1, 10'h3E0, "R9");
      lk(12'd999, 1, 10'h3EF, "R9");
      lk(12'd203, 1, 10'd4, "R9");
      run(mk_cmd(3'd4, 4'd12, 12'd0, 1'b1), n);
      lk(12'd100, 1, 10'h3E0, "R9");
      lk(12'd999, 1, 10'h3EF, "R9");
   endtask

   task automatic t_busy;
      logic [31:0] d0;
      d0 = data_rdata;
      issue(mk_cmd(3'd0, 4'd0, 12'd1, 1'b1));
      repeat (DEPTH - 1) @(negedge clk);
      check(cmd_rdata[3] == 1'b1, "R3", cmd_rdata, 32'h8);
      cmd_we = 1'b1; cmd_wdata = mk_cmd(3'd2, 4'd0, 12'd777, 1'b1);
      data_we = 1'b1; data_wdata = 32'h0000_0801;
      @(posedge clk); @(negedge clk);
      cmd_we = 1'b0; data_we = 1'b0;
      check(cmd_rdata[3] == 1'b0, "R4", cmd_rdata, 0);
      check(cmd_rdata[2:0] == 3'd0, "R4", cmd_rdata, 0);
      check(data_rdata == d0, "R4", data_rdata, d0);
      repeat (DEPTH + 2) @(negedge clk);
      lk(12'd777, 0, '0, "R4");
   endtask

   task automatic t_flush;
      int n;
      run(mk_cmd(3'd1, 4'd0, 12'd0, 1'b1), n);
      check(n == DEPTH, "R3", n, DEPTH);
      lk(12'd100, 0, '0, "R10");
      lk(12'd999, 0, '0, "R10");
      lk(12'd201, 0, '0, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_fields;
      t_timing;
      t_load;
      t_fill;
      t_purge;
      t_rmport;
      t_busy;
      t_flush;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule